// File: doc/BRIEF.md
# Vector Lane Swizzle Sequencer with Constant Injection

This block rearranges the lanes of short sub-vectors. A vector of `vl` elements is processed one element per clock. Each source element is a sub-vector of 1 to 4 lanes, and each destination element is a sub-vector of 1 to 4 lanes. For every element, a 16-bit selector word holds one 3-bit field per destination lane. Each field either names a lane of the current source sub-vector or names an entry of a fixed constant table that depends on the lane type (8 or 16 bits).

The caller presents the flattened source lanes, the selector words and the configuration, then pulses `start`. The block reports `busy` while it works and pulses `done` when it finishes. If a selector is malformed, the block raises `illegal` and stops at the offending element. That element, and every element after it, leaves the destination untouched. The destination lanes live in registers inside the block and are visible at all times on `dst_flat`.

Top module: `vswz_const_top`

## Requirements
- R1: After reset `busy`, `done` and `illegal` are 0 and every destination lane reads 0.
- R2: A `start` seen while idle is accepted. `busy` is 1 from the next cycle and one element is processed per cycle. `done` is 1 for exactly one cycle, `vl` cycles after the accepting edge, and `busy` falls on the cycle after that. A `start` seen while busy is ignored.
- R3: Destination lane i (x=0, y=1, z=2, w=3) is steered by selector bits [3i+2:3i]. When bit 3i+2 is 0, the lane takes source lane number bits[3i+1:3i] from the sub-vector that starts at flat source lane `index*src_subvl`.
- R4: When bit 3i+2 is 1, the lane takes constant number bits[3i+1:3i]. In 16-bit mode (`wide_elem`=1) the table is {0x0000, 0x0001, 0xFFFF, 0x7FFF}. In 8-bit mode (`wide_elem`=0) it is {0x00, 0x01, 0xFF, 0x7F}.
- R5: In 8-bit mode a copied source lane keeps only its low 8 bits, and bits 15:8 of the result are 0.
- R6: The lane i result of element `index` is written to flat destination lane `index*dst_subvl + i`, and only for i < `dst_subvl`. All other destination lanes keep their values.
- R7: Any nonzero selector bit at or above position `3*dst_subvl` flags the element as illegal.
- R8: An active field (i < `dst_subvl`) whose low two bits are at least `src_subvl` flags the element as illegal. This applies whether the field selects a source lane or a constant.
- R9: On an illegal element nothing of that element is written, no later element is processed, and `done` pulses in the cycle in which `illegal` rises. `illegal` then holds until the next accepted `start` clears it.
- R10: When `vl` is 0 or `dst_subvl` is 0, no lane is written and `done` pulses in the first cycle after the accepting edge.
- R11: A `dst_subvl` or `src_subvl` value above 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, accepted only when idle |
| vl | input | $clog2(MAX_VL+1) | Number of elements to process (at most MAX_VL) |
| dst_subvl | input | 3 | Lanes per destination element |
| src_subvl | input | 3 | Lanes per source element |
| wide_elem | input | 1 | 1 = 16-bit lanes, 0 = 8-bit lanes |
| src_flat | input | MAX_VL*64 | Source lanes, flat lane n at bits [16n+15:16n], held while busy |
| sel_flat | input | MAX_VL*16 | Selector words, element v at bits [16v+15:16v], held while busy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Malformed selector seen in the last operation |
| dst_flat | output | MAX_VL*64 | Destination lanes, flat lane n at bits [16n+15:16n] |

## Verification
The bench targets the edge cases listed here, and for each it notes what a faulty design would produce:
- Source and destination sub-vectors of different lengths. A block that shares one stride between them reads or writes the wrong flat lanes.
- Constants in both lane widths, together with source lanes whose upper byte is nonzero. A block that does not mask in 8-bit mode leaks that byte.
- Stray selector bits just above the last active field.
- Constant fields whose index is not below the source length. A block that checks the bound only on the source path misses this trap.
- Zero lengths, oversized lengths and a `start` pulse during a run. These expose a bad length clamp or a restart while busy.

After every trap, the bench confirms that the failing element and all later ones left the destination unchanged.

// File: rtl/vswz_pkg.sv
package vswz_pkg;

    localparam int ELEM_W  = 16;
    localparam int LANES   = 4;
    localparam int FIELD_W = 3;
    localparam int SEL_W   = 16;

    typedef logic [ELEM_W-1:0] elem_t;
    typedef logic [LANES-1:0][ELEM_W-1:0] lane_vec_t;
    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        elem_t value;
        logic  bad;
    } lane_res_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

    function automatic elem_t const_value(input logic [1:0] k, input logic wide);
        elem_t v;
        case (k)
            2'd0:    v = 16'h0000;
            2'd1:    v = 16'h0001;
            2'd2:    v = wide ? 16'hFFFF : 16'h00FF;
            default: v = wide ? 16'h7FFF : 16'h007F;
        endcase
        return v;
    endfunction

    function automatic logic [2:0] clamp_subvl(input logic [2:0] v);
        return (v > 3'd4) ? 3'd4 : v;
    endfunction

endpackage

// File: rtl/vswz_lane_pick.sv
module vswz_lane_pick
    import vswz_pkg::*;
(
    input  field_t     field,
    input  logic       active,
    input  logic [2:0] ssub,
    input  logic       wide,
    input  lane_vec_t  src_sub,
    output lane_res_t  res
);
    logic [1:0] pick;
    elem_t      raw;

    always_comb begin
        pick      = field[1:0];
        raw       = src_sub[pick];
        res.bad   = active && ({1'b0, pick} >= ssub);
        if (field[2])
            res.value = const_value(pick, wide);
        else if (wide)
            res.value = raw;
        else
            res.value = {8'h00, raw[7:0]};
    end
endmodule

// File: rtl/vswz_elem_unit.sv
module vswz_elem_unit
    import vswz_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [2:0]       dsub,
    input  logic [2:0]       ssub,
    input  logic             wide,
    input  lane_vec_t        src_sub,
    output lane_vec_t        lanes,
    output logic             trap
);
    lane_res_t        res [LANES];
    logic [LANES-1:0] bad_vec;
    logic [4:0]       shamt;
    logic             hi_bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vswz_lane_pick u_pick (
            .field   (sel[FIELD_W*i +: FIELD_W]),
            .active  (3'(i) < dsub),
            .ssub    (ssub),
            .wide    (wide),
            .src_sub (src_sub),
            .res     (res[i])
        );
        assign lanes[i]   = res[i].value;
        assign bad_vec[i] = res[i].bad;
    end

    always_comb begin
        shamt  = 5'(dsub) * 5'd3;
        hi_bad = (sel >> shamt) != '0;
        trap   = hi_bad || (|bad_vec);
    end
endmodule

// File: rtl/vswz_seq.sv
module vswz_seq
    import vswz_pkg::*;
#(
    parameter int MAX_VL = 8,
    localparam int VLW = $clog2(MAX_VL + 1),
    localparam int IW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [VLW-1:0] vl,
    input  logic [2:0]     dsub_eff,
    input  logic           trap_in,
    output logic [IW-1:0]  idx,
    output logic           accept,
    output logic           run,
    output logic           busy,
    output logic           done
);
    seq_state_t     state;
    logic [VLW-1:0] vl_q;

    assign accept = (state == ST_IDLE) && start;
    assign run    = (state == ST_RUN);
    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            vl_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    idx   <= '0;
                    vl_q  <= vl;
                    state <= (vl == '0 || dsub_eff == 3'd0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    if (trap_in || int'(idx) == int'(vl_q) - 1)
                        state <= ST_FIN;
                    else
                        idx <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: completion is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2: accepted start makes the block busy next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
    // R2: element index never passes the latched length
    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        run |-> (int'(idx) < int'(vl_q)));
    // R10: empty operation goes straight to completion
    p_empty_fin_r10: assert property (@(posedge clk) disable iff (rst)
        (accept && (vl == '0 || dsub_eff == 3'd0)) |=> done);
endmodule

// File: rtl/vswz_const_top.sv
module vswz_const_top
    import vswz_pkg::*;
#(
    parameter int MAX_VL = 8,
    localparam int VLW = $clog2(MAX_VL + 1),
    localparam int TOT = MAX_VL * LANES,
    localparam int IW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [VLW-1:0]          vl,
    input  logic [2:0]              dst_subvl,
    input  logic [2:0]              src_subvl,
    input  logic                    wide_elem,
    input  logic [TOT*ELEM_W-1:0]   src_flat,
    input  logic [MAX_VL*SEL_W-1:0] sel_flat,
    output logic                    busy,
    output logic                    done,
    output logic                    illegal,
    output logic [TOT*ELEM_W-1:0]   dst_flat
);
    typedef struct packed {
        logic [2:0] dsub;
        logic [2:0] ssub;
        logic       wide;
    } cfg_t;

    cfg_t             cfg_q;
    logic [IW-1:0]    idx;
    logic             accept, run, trap;
    logic [SEL_W-1:0] cur_sel;
    lane_vec_t        src_sub, lanes;
    elem_t            dst_q [TOT];
    logic             illegal_q;

    vswz_seq #(.MAX_VL(MAX_VL)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .vl       (vl),
        .dsub_eff (clamp_subvl(dst_subvl)),
        .trap_in  (trap),
        .idx      (idx),
        .accept   (accept),
        .run      (run),
        .busy     (busy),
        .done     (done)
    );

    always_comb begin
        int base;
        base    = int'(idx) * int'(cfg_q.ssub);
        cur_sel = sel_flat[int'(idx)*SEL_W +: SEL_W];
        for (int j = 0; j < LANES; j++) begin
            if (base + j < TOT)
                src_sub[j] = src_flat[(base + j)*ELEM_W +: ELEM_W];
            else
                src_sub[j] = '0;
        end
    end

    vswz_elem_unit u_elem (
        .sel     (cur_sel),
        .dsub    (cfg_q.dsub),
        .ssub    (cfg_q.ssub),
        .wide    (cfg_q.wide),
        .src_sub (src_sub),
        .lanes   (lanes),
        .trap    (trap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            illegal_q <= 1'b0;
        end else if (accept) begin
            cfg_q.dsub <= clamp_subvl(dst_subvl);
            cfg_q.ssub <= clamp_subvl(src_subvl);
            cfg_q.wide <= wide_elem;
            illegal_q  <= 1'b0;
        end else if (run && trap) begin
            illegal_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < TOT; p++) dst_q[p] <= '0;
        end else if (run && !trap) begin
            for (int i = 0; i < LANES; i++) begin
                if (3'(i) < cfg_q.dsub &&
                    int'(idx) * int'(cfg_q.dsub) + i < TOT)
                    dst_q[int'(idx) * int'(cfg_q.dsub) + i] <= lanes[i];
            end
        end
    end

    for (genvar p = 0; p < TOT; p++) begin : g_out
        assign dst_flat[p*ELEM_W +: ELEM_W] = dst_q[p];
    end
    assign illegal = illegal_q;

    // R9: the trap flag rises together with the completion pulse
    p_trap_done_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(illegal_q) |-> done);
    // R9: a trapping element writes nothing
    p_trap_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        (run && trap) |=> $stable(dst_flat));
    // R6: destination only changes while elements are processed
    p_idle_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(dst_flat));
    // R3: selectors must be held while a run is in progress
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(sel_flat));
endmodule

// File: tb/vswz_const_top_bench.sv
module vswz_const_top_bench;
    localparam int MAX_VL = 8;
    localparam int TOT    = MAX_VL * 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [3:0]        vl_in;
    logic [2:0]        dsub_in, ssub_in;
    logic              wide_in;
    logic [TOT*16-1:0] src_flat;
    logic [MAX_VL*16-1:0] sel_flat;
    logic              busy, done, illegal;
    logic [TOT*16-1:0] dst_flat;

    logic [15:0] src_m [TOT];
    logic [15:0] sel_m [MAX_VL];
    logic [15:0] exp_dst [TOT];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vswz_const_top #(.MAX_VL(MAX_VL)) u_vswz_const_top (
        .clk(clk), .rst(rst), .start(start), .vl(vl_in),
        .dst_subvl(dsub_in), .src_subvl(ssub_in), .wide_elem(wide_in),
        .src_flat(src_flat), .sel_flat(sel_flat),
        .busy(busy), .done(done), .illegal(illegal), .dst_flat(dst_flat)
    );

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_dst(input string tag);
        int bad_p = -1;
        for (int p = 0; p < TOT; p++)
            if (bad_p < 0 && dst_flat[p*16 +: 16] !== exp_dst[p]) bad_p = p;
        if (bad_p < 0) check_val(tag, 0, 0);
        else check_val($sformatf("%s lane%0d", tag, bad_p),
                       32'(dst_flat[bad_p*16 +: 16]), 32'(exp_dst[bad_p]));
    endtask

    function automatic logic [15:0] cst(input int k, input bit wide);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return wide ? 16'hFFFF : 16'h00FF;
            default: return wide ? 16'h7FFF : 16'h007F;
        endcase
    endfunction

    function automatic logic [15:0] mk(input int f0, input int f1, input int f2, input int f3);
        return 16'(f0 | (f1 << 3) | (f2 << 6) | (f3 << 9));
    endfunction

    // Reference: one element; returns 1 on trap, else writes exp_dst
    task automatic model_elem(input int e, input int de, input int se, input bit wide, output bit trapped);
        logic [15:0] sv = sel_m[e];
        logic [15:0] tmp [4];
        trapped = ((32'(sv) >> (3*de)) != 0);
        for (int i = 0; i < de; i++) begin
            int f  = (int'(sv) >> (3*i)) & 7;
            int lo = f & 3;
            tmp[i] = 16'h0;
            if (lo >= se) trapped = 1;
            else if (f >= 4) tmp[i] = cst(lo, wide);
            else tmp[i] = wide ? src_m[e*se+lo] : (src_m[e*se+lo] & 16'h00FF);
        end
        if (!trapped)
            for (int i = 0; i < de; i++) exp_dst[e*de+i] = tmp[i];
    endtask

    task automatic run_op(input int vl, input int d, input int s, input bit wide,
                          input bit poke, input string tag);
        int de = (d > 4) ? 4 : d;
        int se = (s > 4) ? 4 : s;
        bit trapped = 0;
        for (int n = 0; n < TOT; n++) src_flat[n*16 +: 16] = src_m[n];
        for (int v = 0; v < MAX_VL; v++) sel_flat[v*16 +: 16] = sel_m[v];
        vl_in = 4'(vl); dsub_in = 3'(d); ssub_in = 3'(s); wide_in = wide;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (vl != 0 && de != 0) begin
            for (int e = 0; e < vl; e++) begin
                check_val({tag, " R2 busy"}, 32'(busy), 1);
                check_val({tag, " R2 done early"}, 32'(done), 0);
                check_val({tag, " R9 illegal cleared"}, 32'(illegal), 0);
                check_dst({tag, " R6 progress"});
                if (poke && e == 1) begin start = 1'b1; vl_in = 4'd1; end
                @(negedge clk);
                start = 1'b0; vl_in = 4'(vl);
                model_elem(e, de, se, wide, trapped);
                if (trapped) break;
            end
        end
        check_val({tag, " R2/R10 done"}, 32'(done), 1);
        check_val({tag, " R7/R8/R9 illegal"}, 32'(illegal), 32'(trapped));
        check_dst({tag, " R3/R4/R5/R6 result"});
        @(negedge clk);
        check_val({tag, " R2 idle"}, 32'({busy, done}), 0);
        check_val({tag, " R9 illegal held"}, 32'(illegal), 32'(trapped));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; vl_in = '0; dsub_in = '0; ssub_in = '0;
        wide_in = 1'b1; src_flat = '0; sel_flat = '0;
        for (int n = 0; n < TOT; n++) begin
            src_m[n]   = 16'hA000 + 16'(n * 16'h0111);
            exp_dst[n] = 16'h0;
        end
        for (int v = 0; v < MAX_VL; v++) sel_m[v] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_val("R1 flags", 32'({busy, done, illegal}), 0);
        check_dst("R1 dst zero");

        // R3 identity x,y,z,w 16-bit
        for (int v = 0; v < 4; v++) sel_m[v] = mk(0, 1, 2, 3);
        run_op(4, 4, 4, 1, 0, "identity");

        // R3 R5 R6 different strides, 8-bit, reverse
        for (int v = 0; v < 3; v++) sel_m[v] = mk(2, 0, 0, 0);
        sel_m[1] = mk(1, 2, 0, 0);
        run_op(3, 2, 3, 0, 0, "stride8");

        // R4 constants both widths
        for (int v = 0; v < 2; v++) sel_m[v] = mk(4, 5, 6, 7);
        run_op(2, 4, 4, 0, 0, "const8");
        run_op(2, 4, 4, 1, 0, "const16");

        // R7 stray bit just above last active field, element 2
        for (int v = 0; v < 4; v++) sel_m[v] = mk(1, 0, 0, 0);
        sel_m[2] = mk(0, 1, 1, 0);
        run_op(4, 2, 2, 1, 0, "hibits");

        // R8 source index out of range at element 1
        for (int v = 0; v < 3; v++) sel_m[v] = mk(1, 0, 0, 0);
        sel_m[1] = mk(0, 3, 0, 0);
        run_op(3, 2, 2, 1, 0, "srcrange");

        // R8 constant field with index not below src length
        sel_m[0] = mk(4, 0, 0, 0);
        sel_m[1] = mk(5, 0, 0, 0);
        run_op(2, 1, 1, 1, 0, "constrange");

        // R10 empty operations
        run_op(0, 4, 4, 1, 0, "vl0");
        run_op(3, 0, 4, 1, 0, "dsub0");

        // R11 oversized lengths clamp to 4
        for (int v = 0; v < 3; v++) sel_m[v] = mk(3, 2, 1, 0);
        run_op(3, 7, 6, 1, 0, "clamp");

        // R2 start ignored while busy, full length
        for (int v = 0; v < MAX_VL; v++) sel_m[v] = mk(v % 4, (v + 1) % 4, 4 + v % 4, 0);
        run_op(MAX_VL, 3, 4, 1, 1, "full");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule